// File: doc/BRIEF.md
# Paged Address Translation Unit

This block widens a 16-bit processor address into a 24-bit system address. The processor space is cut into sixteen 4 KB pages. Each page owns a 12-bit mapping entry made of a 4-bit region nibble and an 8-bit page number. The translated address is that entry followed by the untouched 12-bit offset. The top nibble of the result picks one of sixteen 1 MB regions. The block decodes the regions that hold devices into a one-hot select.

Translation is purely combinational from the processor address. Software changes the mapping through a small Wishbone slave port, with one word address per page. Reset loads a fixed default layout. In that layout several low pages mirror others, and page 0 mirrors the monitor page.

Top module: `page_xlate_unit`

## Requirements
- R1: `sysAddr[23:12]` equals the mapping entry selected by `cpuAddr[15:12]`. The entry's nibble lands in `sysAddr[23:20]` and its page number in `sysAddr[19:12]`.
- R2: `sysAddr[11:0]` always equals `cpuAddr[11:0]`.
- R3: `regionSel` is one-hot or zero, decoded from `sysAddr[23:20]` as follows:
  - nibble 0 sets bit 0 (bus I/O)
  - nibble 1 sets bit 1 (SRAM)
  - nibble 2 sets bit 2 (flash)
  - nibble 6 sets bit 3 (video)
  - nibble 8 sets bit 4 (SDRAM)
  - nibble E sets bit 5 (keyboard)
  - nibble F sets bit 6 (this unit)
  - any other nibble sets no bit.
- R4: After reset the entries for pages 0 to F are 103, 101, 102, 103, 101, 102, 103, 101, 800, 801, 802, 803, 200, F00, 103 and 600 (hex).
- R5: `wbAck` rises one clock after `wbStb` and `wbCyc` are both high and stays high for exactly one cycle. While the master holds the strobe through the ack cycle, no second ack follows directly.
- R6: A write to word address k (`wbAdr[3:0]`) updates entry k. `wbSel[0]` enables bits [7:0] from `wbDatI[7:0]` and `wbSel[1]` enables bits [11:8] from `wbDatI[11:8]`. An unselected field keeps its value.
- R7: During the ack cycle of a read, `wbDatO` holds the addressed entry zero-extended to 32 bits.
- R8: A written entry still translates with its old value during the ack cycle. It translates with the new value from the next cycle on.
- R9: Asserting the asynchronous active-low `rstN` reloads the whole default table, overwriting earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Processor address |
| sysAddr | output | 24 | Translated system address |
| regionSel | output | 7 | One-hot device region select |
| wbAdr | input | 4 | Slave word address (entry index) |
| wbDatI | input | 32 | Slave write data |
| wbDatO | output | 32 | Slave read data |
| wbSel | input | 4 | Byte selects |
| wbWe | input | 1 | Write enable |
| wbStb | input | 1 | Strobe |
| wbCyc | input | 1 | Cycle valid |
| wbAck | output | 1 | Acknowledge |

## Verification
The embedded properties check the following on every cycle:
- the select is one-hot or zero
- the ack is a single-cycle pulse that only follows a request
- no register write happens outside an ack cycle
- a committed field holds the written data afterwards.

The bench scenarios show the rest:
- the default table and its shadowed pages
- the exact region decode, including unmapped nibbles
- partial byte-select writes and zero-extended reads
- the old-then-new translation around a write
- a reset that overwrites earlier writes.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 4;
  localparam int HI_W    = 4;
  localparam int LO_W    = 8;
  localparam int MAP_W   = HI_W + LO_W;
  localparam int CPU_W   = IDX_W + OFF_W;
  localparam int SYS_W   = MAP_W + OFF_W;
  localparam int PAGES   = 1 << IDX_W;
  localparam int NREGION = 7;
  localparam int BUS_W   = 32;

  typedef struct packed {
    logic             wrLo;
    logic             wrHi;
    logic [IDX_W-1:0] idx;
  } patStrobe_t;

  function automatic logic [HI_W-1:0] regionCode(input int r);
    case (r)
      0:       return 4'h0;
      1:       return 4'h1;
      2:       return 4'h2;
      3:       return 4'h6;
      4:       return 4'h8;
      5:       return 4'hE;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [MAP_W-1:0] resetMap(input int p);
    case (p % 16)
      0, 3, 6, 14: return 12'h103;
      1, 4, 7:     return 12'h101;
      2, 5:        return 12'h102;
      8:           return 12'h800;
      9:           return 12'h801;
      10:          return 12'h802;
      11:          return 12'h803;
      12:          return 12'h200;
      13:          return 12'hF00;
      default:     return 12'h600;
    endcase
  endfunction
endpackage

// File: rtl/pat_ctrl.sv
module pat_ctrl
  import pat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wbStb,
  input  logic             wbCyc,
  input  logic             wbWe,
  input  logic [3:0]       wbSel,
  input  logic [IDX_W-1:0] wbAdr,
  output logic             wbAck,
  output patStrobe_t       strobe
);
  logic req;
  logic ackQ;

  assign req = wbStb & wbCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= req & ~ackQ;
  end

  assign wbAck = ackQ;

  // commit happens on the edge that closes the ack cycle
  always_comb begin
    strobe.wrLo = ackQ & req & wbWe & wbSel[0];
    strobe.wrHi = ackQ & req & wbWe & wbSel[1];
    strobe.idx  = wbAdr;
  end

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck);

  // R5
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbAck) |-> $past(wbStb && wbCyc));
endmodule

// File: rtl/pat_regs.sv
module pat_regs
  import pat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  patStrobe_t         strobe,
  input  logic [MAP_W-1:0]   wrData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [MAP_W-1:0]   rdData,
  input  logic [CPU_W-1:0]   cpuAddr,
  output logic [SYS_W-1:0]   sysAddr,
  output logic [NREGION-1:0] regionSel
);
  logic [MAP_W-1:0] mapQ [PAGES];
  logic [IDX_W-1:0] pageIdx;
  logic [HI_W-1:0]  topNib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < PAGES; p++) mapQ[p] <= resetMap(p);
    end else begin
      if (strobe.wrLo) mapQ[strobe.idx][LO_W-1:0] <= wrData[LO_W-1:0];
      if (strobe.wrHi) mapQ[strobe.idx][MAP_W-1:LO_W] <= wrData[MAP_W-1:LO_W];
    end
  end

  assign pageIdx = cpuAddr[CPU_W-1:OFF_W];
  assign sysAddr = {mapQ[pageIdx], cpuAddr[OFF_W-1:0]};
  assign rdData  = mapQ[rdIdx];
  assign topNib  = sysAddr[SYS_W-1:SYS_W-HI_W];

  for (genvar r = 0; r < NREGION; r++) begin : g_region
    assign regionSel[r] = (topNib == regionCode(r));
  end

  // R3
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel));

  // R6
  wr_lo_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLo |=> mapQ[$past(strobe.idx)][LO_W-1:0] == $past(wrData[LO_W-1:0]));

  // R6
  wr_hi_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHi |=> mapQ[$past(strobe.idx)][MAP_W-1:LO_W] == $past(wrData[MAP_W-1:LO_W]));
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        cpuAddr,
  output logic [23:0]        sysAddr,
  output logic [6:0]         regionSel,
  input  logic [3:0]         wbAdr,
  input  logic [31:0]        wbDatI,
  output logic [31:0]        wbDatO,
  input  logic [3:0]         wbSel,
  input  logic               wbWe,
  input  logic               wbStb,
  input  logic               wbCyc,
  output logic               wbAck
);
  patStrobe_t       strobe;
  logic [MAP_W-1:0] rdData;

  pat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wbStb(wbStb), .wbCyc(wbCyc), .wbWe(wbWe),
    .wbSel(wbSel), .wbAdr(wbAdr), .wbAck(wbAck), .strobe(strobe)
  );

  pat_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wbDatI[MAP_W-1:0]),
    .rdIdx(wbAdr), .rdData(rdData), .cpuAddr(cpuAddr), .sysAddr(sysAddr),
    .regionSel(regionSel)
  );

  assign wbDatO = {{(BUS_W-MAP_W){1'b0}}, rdData};

  // R8
  write_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrLo || strobe.wrHi) |-> wbAck);
endmodule

// File: tb/page_xlate_unit_tb.sv
module page_xlate_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [23:0] sysAddr;
  logic [6:0]  regionSel;
  logic [3:0]  wbAdr = '0;
  logic [31:0] wbDatI = '0;
  logic [31:0] wbDatO;
  logic [3:0]  wbSel = '0;
  logic        wbWe = 1'b0, wbStb = 1'b0, wbCyc = 1'b0;
  logic        wbAck;

  int nTests = 0;
  int nFail = 0;

  logic [23:0] expAddrQ [$];
  logic [6:0]  expRegQ  [$];
  string       tagQ     [$];

  page_xlate_unit u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .sysAddr(sysAddr),
    .regionSel(regionSel), .wbAdr(wbAdr), .wbDatI(wbDatI), .wbDatO(wbDatO),
    .wbSel(wbSel), .wbWe(wbWe), .wbStb(wbStb), .wbCyc(wbCyc), .wbAck(wbAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] expRegion(input logic [3:0] n);
    case (n)
      4'h0: return 7'b0000001;
      4'h1: return 7'b0000010;
      4'h2: return 7'b0000100;
      4'h6: return 7'b0001000;
      4'h8: return 7'b0010000;
      4'hE: return 7'b0100000;
      4'hF: return 7'b1000000;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [11:0] defEntry(input int p);
    logic [11:0] t [16] = '{12'h103, 12'h101, 12'h102, 12'h103, 12'h101, 12'h102,
                            12'h103, 12'h101, 12'h800, 12'h801, 12'h802, 12'h803,
                            12'h200, 12'hF00, 12'h103, 12'h600};
    return t[p];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: present an address, queue the expected translation
  task automatic xlate(input logic [15:0] a, input logic [11:0] entry, input string tag);
    @(posedge clk); #1;
    cpuAddr = a;
    expAddrQ.push_back({entry, a[11:0]});
    expRegQ.push_back(expRegion(entry[11:8]));
    tagQ.push_back(tag);
  endtask

  // monitor: compare one queued item per cycle
  always @(negedge clk) begin
    if (expAddrQ.size() > 0) begin
      logic [23:0] ea;
      logic [6:0]  er;
      string       tg;
      ea = expAddrQ.pop_front();
      er = expRegQ.pop_front();
      tg = tagQ.pop_front();
      check({tg, " addr"}, {8'h0, sysAddr}, {8'h0, ea});
      check({tg, " region"}, {25'h0, regionSel}, {25'h0, er});
    end
  end

  task automatic drain();
    while (expAddrQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // bus access; returns read data captured in the ack cycle
  task automatic busOp(input logic we, input logic [3:0] adr, input logic [31:0] d,
                       input logic [3:0] sel, output logic [31:0] rd);
    @(posedge clk); #1;
    wbWe = we; wbAdr = adr; wbDatI = d; wbSel = sel; wbStb = 1'b1; wbCyc = 1'b1;
    @(negedge clk);
    check("R5 no early ack", {31'h0, wbAck}, 32'h0);
    @(negedge clk);
    check("R5 ack one cycle after strobe", {31'h0, wbAck}, 32'h1);
    rd = wbDatO;
    @(posedge clk); #1;
    wbStb = 1'b0; wbCyc = 1'b0; wbWe = 1'b0;
    @(negedge clk);
    check("R5 ack single cycle", {31'h0, wbAck}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    #(CLK_PERIOD * 3);
    rstN = 1'b1;

    // R4 R1 R2 R3: default table through every page, varied offsets
    for (int p = 0; p < 16; p++)
      xlate({p[3:0], 12'h5A0 ^ {p[3:0], 8'h0F}}, defEntry(p), "R4 default");
    xlate(16'h0FFF, 12'h103, "R2 offset all ones");
    xlate(16'hF000, 12'h600, "R2 offset zero");
    drain();

    // R7: reads return zero-extended entries
    busOp(1'b0, 4'hD, 32'hFFFF_FFFF, 4'hF, rd);
    check("R7 read page D", rd, 32'h0000_0F00);
    busOp(1'b0, 4'h8, 32'h0, 4'hF, rd);
    check("R7 read page 8", rd, 32'h0000_0800);

    // R8: old value during ack, new value afterwards
    @(posedge clk); #1; cpuAddr = 16'h4123;
    @(posedge clk); #1;
    wbWe = 1'b1; wbAdr = 4'h4; wbDatI = 32'h0000_03AB; wbSel = 4'h3; wbStb = 1'b1; wbCyc = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 ack present", {31'h0, wbAck}, 32'h1);
    check("R8 old value during ack", {8'h0, sysAddr}, 32'h0010_1123);
    @(posedge clk); #1; wbStb = 1'b0; wbCyc = 1'b0; wbWe = 1'b0;
    @(negedge clk);
    check("R8 new value after ack", {8'h0, sysAddr}, 32'h003A_B123);
    // R3: nibble 3 is unmapped
    check("R3 unmapped nibble", {25'h0, regionSel}, 32'h0);

    // R6: low byte only keeps the nibble; high nibble only keeps the byte
    busOp(1'b1, 4'h9, 32'h0000_0FFF, 4'h1, rd);
    busOp(1'b1, 4'hA, 32'h0000_0E55, 4'h2, rd);
    busOp(1'b1, 4'h1, 32'h0000_0000, 4'h0, rd);
    xlate(16'h9001, 12'h8FF, "R6 low byte only");
    xlate(16'hA002, 12'hE02, "R6 high nibble only");
    xlate(16'h1003, 12'h101, "R6 no byte selected");
    xlate(16'h4004, 12'h3AB, "R3 R6 unmapped region");
    drain();
    busOp(1'b0, 4'h9, 32'h0, 4'hF, rd);
    check("R6 R7 readback", rd, 32'h0000_08FF);

    // R5: strobe held through ack gets no back-to-back second ack
    @(posedge clk); #1; wbStb = 1'b1; wbCyc = 1'b1; wbAdr = 4'h0;
    @(negedge clk); @(negedge clk);
    check("R5 held strobe ack", {31'h0, wbAck}, 32'h1);
    @(negedge clk);
    check("R5 no back-to-back ack", {31'h0, wbAck}, 32'h0);
    @(posedge clk); #1; wbStb = 1'b0; wbCyc = 1'b0;
    @(posedge clk);

    // R9: async reset restores defaults
    #3 rstN = 1'b0;
    #2;
    check("R9 async reset ack low", {31'h0, wbAck}, 32'h0);
    #(CLK_PERIOD * 2) rstN = 1'b1;
    xlate(16'h4004, 12'h101, "R9 page 4 restored");
    xlate(16'h9010, 12'h801, "R9 page 9 restored");
    xlate(16'hA020, 12'h802, "R9 page A restored");
    drain();

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule